// File: doc/BRIEF.md
# Indexed Register Port with NMI Gate

This block is the host-side front end of a 128-byte clock-and-storage array. The host sees only two byte locations: an index port (offset 0) and a data port (offset 1). Writing the index port latches a 7-bit index in its low bits, and its top bit loads a mask latch. Data-port writes then reach the byte at the latched index. The data-port read output always shows the byte at the latched index. The index stays put until the index port is written again. The mask latch sits between a set of error inputs and the CPU's non-maskable interrupt line. While the latch holds 1, the error inputs cannot reach the line.

Indices 0x00 to 0x0D belong to the time-keeping core, which lies outside this block. For those indices the block forwards a write strobe, the index, the data and a per-bit write mask, and it returns the core's read byte. Indices 0x0E to 0x7F address 114 bytes of plain storage held in a local RAM. Index 0x0E, the diagnostic byte, is part of that storage.

A 16-bit write at the index port does two things in a single bus operation. Its low byte goes to the index port and its high byte goes to the data port at the new index. For example, the value 0x0685 writes 0x06 to index 5 and sets the mask.

Top module: `idx_port_nmi`

## Requirements
- R1: After reset the latched index is 0 and the mask latch is clear: a read of the index port returns 0x00, and `nmi_out` follows the error inputs.
- R2: A write at the index port (`bus_sel`=0) latches `bus_wdata[6:0]` as the index and `bus_wdata[7]` as the mask. An index-port read returns {mask, index} with the mask in bit 7.
- R3: `nmi_out` is 1 exactly when at least one bit of `err_in` is 1 and the mask latch is 0. An index write with bit 7 set blocks it, and a later index write with bit 7 clear re-enables it.
- R4: A data-port write (`bus_sel`=1) at an index from 0x0E to 0x7F stores the byte in local RAM. A later data-port read at that index returns the stored byte.
- R5: At indices 0x00 to 0x0D, a data-port write raises `core_wr` in the same cycle, with `core_idx` set to the index and `core_wdata` set to the byte. At those indices a data-port read returns `core_rdata`. `core_wr` stays 0 for every other access.
- R6: `core_wmask` is 0x00 at indices 0x0C and 0x0D. It is 0x7F at index 0x0A, where bit 7 is the core's busy flag. It is 0xFF at every other core index, so writes to read-only bits are ignored.
- R7: A write with `bus_wide`=1 at the index port latches the index and mask from `bus_wdata[7:0]`. In the same operation it writes `bus_wdata[15:8]` at the new index, to the core or to RAM.
- R8: The index is unchanged by data-port reads and writes. Repeated accesses reach the same byte.
- R9: Index 0x0E is plain read/write storage with all 8 bits writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Port offset: 0 index port, 1 data port |
| bus_wr | input | 1 | Write strobe, one cycle per operation |
| bus_wide | input | 1 | With an index-port write, the high byte is also written as data |
| bus_wdata | input | 16 | Write data; the high byte is used only for wide writes |
| bus_rdata | output | 8 | Read data of the selected port |
| err_in | input | 4 | Error sources for the non-maskable interrupt |
| nmi_out | output | 1 | Gated non-maskable interrupt |
| core_wr | output | 1 | Write strobe to the time-keeping core |
| core_idx | output | 4 | Core register index |
| core_wdata | output | 8 | Core write data |
| core_wmask | output | 8 | Writable bits of the addressed core register |
| core_rdata | input | 8 | Core read data for `core_idx` |

## Verification
The bench walks the index through the RAM region at both ends (0x0E and 0x7F) and through the middle. It then does repeated reads and overwrites at one index, which separates a held index from one that advances or resets. Core writes go to a plain register, the busy-flag register and the two read-only registers, so that each of the three mask values appears at least once. Wide writes go once to a core index and once to a RAM index with the mask bit set; these tell a same-cycle data write apart from one that lands at the old index. The error inputs are held active while the mask is set and then cleared, which shows the gate blocking and releasing.

// File: rtl/idx_port_pkg.sv
package idx_port_pkg;
  localparam int IDX_W    = 7;
  localparam int DAT_W    = 8;
  localparam int CORE_CNT = 14;
  localparam int REG_A    = 10;
  localparam int REG_C    = 12;
  localparam int REG_D    = 13;
  localparam int BUSY_BIT = 7;
endpackage

// File: rtl/idx_latch.sv
module idx_latch #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W:0]   din,
  output logic [IDX_W-1:0] idx,
  output logic             mask
);
  logic [IDX_W-1:0] idx_d;
  logic             mask_d;

  always_comb begin
    idx_d  = idx;
    mask_d = mask;
    if (load) begin
      idx_d  = din[IDX_W-1:0];
      mask_d = din[IDX_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      mask <= 1'b0;
    end else begin
      idx  <= idx_d;
      mask <= mask_d;
    end
  end
endmodule

// File: rtl/nvram.sv
module nvram #(
  parameter int IDX_W    = 7,
  parameter int DAT_W    = 8,
  parameter int CORE_CNT = 14
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DAT_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [DAT_W-1:0] rdata
);
  localparam int DEPTH = (1 << IDX_W) - CORE_CNT;
  localparam logic [IDX_W-1:0] BASE = IDX_W'(CORE_CNT);

  logic [DAT_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0] wofs, rofs;

  assign wofs  = waddr - BASE;
  assign rofs  = raddr - BASE;
  assign rdata = (rofs < IDX_W'(DEPTH)) ? mem[rofs] : '0;

  always_ff @(posedge clk) begin
    if (we && (wofs < IDX_W'(DEPTH))) begin
      mem[wofs] <= wdata;
    end
  end
endmodule

// File: rtl/reg_router.sv
module reg_router #(
  parameter int IDX_W    = 7,
  parameter int DAT_W    = 8,
  parameter int CORE_CNT = 14,
  parameter int CW       = 4,
  parameter int REG_A    = 10,
  parameter int REG_C    = 12,
  parameter int REG_D    = 13,
  parameter int BUSY_BIT = 7
) (
  input  logic             dwr,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             port_sel,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             mask,
  input  logic [DAT_W-1:0] core_rdata,
  input  logic [DAT_W-1:0] ram_rdata,
  output logic             core_wr,
  output logic             ram_we,
  output logic [DAT_W-1:0] core_wmask,
  output logic [DAT_W-1:0] rdata
);
  localparam logic [IDX_W-1:0] LIM = IDX_W'(CORE_CNT);
  logic wr_core, rd_core;

  assign wr_core = (wr_idx < LIM);
  assign rd_core = (rd_idx < LIM);
  assign core_wr = dwr & wr_core;
  assign ram_we  = dwr & ~wr_core;

  always_comb begin
    core_wmask = '1;
    if ((wr_idx == IDX_W'(REG_C)) || (wr_idx == IDX_W'(REG_D))) begin
      core_wmask = '0;
    end else if (wr_idx == IDX_W'(REG_A)) begin
      core_wmask[BUSY_BIT] = 1'b0;
    end
  end

  always_comb begin
    if (!port_sel) begin
      rdata = '0;
      rdata[DAT_W-1] = mask;
      rdata[IDX_W-1:0] = rd_idx;
    end else if (rd_core) begin
      rdata = core_rdata;
    end else begin
      rdata = ram_rdata;
    end
  end
endmodule

// File: rtl/idx_port_nmi.sv
module idx_port_nmi
  import idx_port_pkg::*;
#(
  parameter int P_IDX_W    = IDX_W,
  parameter int P_DAT_W    = DAT_W,
  parameter int P_CORE_CNT = CORE_CNT,
  parameter int ERR_W      = 4,
  parameter int CW         = $clog2(P_CORE_CNT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic                 bus_wide,
  input  logic [2*P_DAT_W-1:0] bus_wdata,
  output logic [P_DAT_W-1:0]   bus_rdata,
  input  logic [ERR_W-1:0]     err_in,
  output logic                 nmi_out,
  output logic                 core_wr,
  output logic [CW-1:0]        core_idx,
  output logic [P_DAT_W-1:0]   core_wdata,
  output logic [P_DAT_W-1:0]   core_wmask,
  input  logic [P_DAT_W-1:0]   core_rdata
);
  logic                 addr_wr, wide_wr, dwr, ram_we, nmi_mask;
  logic [P_IDX_W-1:0]   cur_idx, tgt_idx;
  logic [P_DAT_W-1:0]   tgt_dat, ram_rdata;

  assign addr_wr = bus_wr & ~bus_sel;
  assign wide_wr = addr_wr & bus_wide;
  assign dwr     = (bus_wr & bus_sel) | wide_wr;
  assign tgt_idx = wide_wr ? bus_wdata[P_IDX_W-1:0] : cur_idx;
  assign tgt_dat = wide_wr ? bus_wdata[2*P_DAT_W-1:P_DAT_W] : bus_wdata[P_DAT_W-1:0];

  idx_latch #(.IDX_W(P_IDX_W)) u_latch (
    .clk  (clk),
    .rst_n(rst_n),
    .load (addr_wr),
    .din  (bus_wdata[P_IDX_W:0]),
    .idx  (cur_idx),
    .mask (nmi_mask)
  );

  nvram #(.IDX_W(P_IDX_W), .DAT_W(P_DAT_W), .CORE_CNT(P_CORE_CNT)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(tgt_idx),
    .wdata(tgt_dat),
    .raddr(cur_idx),
    .rdata(ram_rdata)
  );

  reg_router #(
    .IDX_W(P_IDX_W), .DAT_W(P_DAT_W), .CORE_CNT(P_CORE_CNT), .CW(CW),
    .REG_A(REG_A), .REG_C(REG_C), .REG_D(REG_D), .BUSY_BIT(BUSY_BIT)
  ) u_route (
    .dwr       (dwr),
    .wr_idx    (tgt_idx),
    .port_sel  (bus_sel),
    .rd_idx    (cur_idx),
    .mask      (nmi_mask),
    .core_rdata(core_rdata),
    .ram_rdata (ram_rdata),
    .core_wr   (core_wr),
    .ram_we    (ram_we),
    .core_wmask(core_wmask),
    .rdata     (bus_rdata)
  );

  assign core_idx   = tgt_idx[CW-1:0];
  assign core_wdata = tgt_dat;
  assign nmi_out    = (|err_in) & ~nmi_mask;
endmodule

// File: rtl/idx_port_nmi_chk.sv
module idx_port_nmi_chk #(
  parameter int IDX_W = 7,
  parameter int DAT_W = 8,
  parameter int CW    = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [2*DAT_W-1:0] bus_wdata,
  input logic               nmi_out,
  input logic               core_wr,
  input logic [CW-1:0]      core_idx,
  input logic [DAT_W-1:0]   core_wmask,
  input logic [IDX_W-1:0]   cur_idx
);
  p_idx_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_sel) |=> (cur_idx == $past(bus_wdata[IDX_W-1:0])));

  p_mask_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_sel && bus_wdata[IDX_W]) |=> !nmi_out);

  p_core_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr |-> bus_wr);

  p_ro_regs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr && (core_idx == CW'(12) || core_idx == CW'(13))) |-> (core_wmask == '0));

  p_idx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && !bus_sel) |=> $stable(cur_idx));
endmodule

bind idx_port_nmi idx_port_nmi_chk #(.IDX_W(P_IDX_W), .DAT_W(P_DAT_W), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .nmi_out   (nmi_out),
  .core_wr   (core_wr),
  .core_idx  (core_idx),
  .core_wmask(core_wmask),
  .cur_idx   (cur_idx)
);

// File: tb/tb_idx_port_nmi.sv
`timescale 1ns/1ps
module tb_idx_port_nmi;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_wide = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [3:0]  err_in = '0;
  logic        nmi_out, core_wr;
  logic [3:0]  core_idx;
  logic [7:0]  core_wdata, core_wmask, core_rdata;
  int          checks = 0, failures = 0;
  bit          done = 1'b0;

  logic [6:0]  m_idx;
  logic        m_mask;
  logic [7:0]  mem [int];

  always #2.5 clk = ~clk;

  assign core_rdata = {4'hC, core_idx};

  idx_port_nmi dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .err_in(err_in), .nmi_out(nmi_out), .core_wr(core_wr),
    .core_idx(core_idx), .core_wdata(core_wdata), .core_wmask(core_wmask),
    .core_rdata(core_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model, updated on each edge from the inputs held before it
  always @(posedge clk) begin
    if (!rst_n) begin
      m_idx  = '0;
      m_mask = 1'b0;
    end else if (bus_wr) begin
      if (!bus_sel) begin
        m_idx  = bus_wdata[6:0];
        m_mask = bus_wdata[7];
        if (bus_wide && bus_wdata[6:0] >= 7'd14) mem[int'(bus_wdata[6:0])] = bus_wdata[15:8];
      end else if (m_idx >= 7'd14) begin
        mem[int'(m_idx)] = bus_wdata[7:0];
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic       exp_cw;
      logic [6:0] t;
      logic [7:0] d, wm;
      chk("R3 nmi_out", nmi_out, (|err_in) & ~m_mask);
      exp_cw = bus_wr && (bus_sel ? (m_idx < 7'd14) : (bus_wide && bus_wdata[6:0] < 7'd14));
      chk(bus_wide ? "R7 core_wr" : "R5 core_wr", core_wr, exp_cw);
      if (exp_cw) begin
        t  = bus_sel ? m_idx : bus_wdata[6:0];
        d  = bus_sel ? bus_wdata[7:0] : bus_wdata[15:8];
        wm = (t == 7'd12 || t == 7'd13) ? 8'h00 : (t == 7'd10) ? 8'h7F : 8'hFF;
        chk(bus_sel ? "R5 core_idx" : "R7 core_idx", core_idx, t[3:0]);
        chk(bus_sel ? "R5 core_wdata" : "R7 core_wdata", core_wdata, d);
        chk("R6 core_wmask", core_wmask, wm);
      end
      if (!bus_sel) chk("R2 index port read", bus_rdata, {m_mask, m_idx});
      else if (m_idx < 7'd14) chk("R5 core read", bus_rdata, {4'hC, m_idx[3:0]});
      else if (mem.exists(int'(m_idx)))
        chk(m_idx == 7'd14 ? "R9 diag byte read" : "R4 ram read", bus_rdata, mem[int'(m_idx)]);
    end
  end

  task automatic op(input logic sel, input logic wr, input logic wide, input logic [15:0] d);
    @(posedge clk); #2;
    bus_sel = sel; bus_wr = wr; bus_wide = wide; bus_wdata = d;
    @(posedge clk); #2;
    bus_wr = 1'b0; bus_wide = 1'b0;
  endtask

  task automatic rd_expect(input string tag, input logic [7:0] exp);
    @(posedge clk); #2;
    bus_sel = 1'b1; bus_wr = 1'b0;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    err_in = 4'b0001;
    @(negedge clk);
    chk("R1 reset index/mask", bus_rdata, 8'h00);
    chk("R1 reset nmi enabled", nmi_out, 1'b1);
    err_in = 4'b0000;

    op(1'b0, 1'b1, 1'b0, 16'h0020);
    op(1'b1, 1'b1, 1'b0, 16'h005A);
    rd_expect("R4 ram 0x20", 8'h5A);
    rd_expect("R8 repeat read", 8'h5A);
    op(1'b1, 1'b1, 1'b0, 16'h0033);
    rd_expect("R8 overwrite same index", 8'h33);

    op(1'b0, 1'b1, 1'b0, 16'h000E);
    op(1'b1, 1'b1, 1'b0, 16'h00C3);
    rd_expect("R9 diag byte", 8'hC3);
    op(1'b0, 1'b1, 1'b0, 16'h007F);
    op(1'b1, 1'b1, 1'b0, 16'h0011);
    rd_expect("R4 top index", 8'h11);

    op(1'b0, 1'b1, 1'b0, 16'h0004);
    op(1'b1, 1'b1, 1'b0, 16'h0012);
    rd_expect("R5 core read idx4", 8'hC4);
    op(1'b0, 1'b1, 1'b0, 16'h000D);
    op(1'b1, 1'b1, 1'b0, 16'h00FF);
    op(1'b0, 1'b1, 1'b0, 16'h000C);
    op(1'b1, 1'b1, 1'b0, 16'h00AA);
    op(1'b0, 1'b1, 1'b0, 16'h000A);
    op(1'b1, 1'b1, 1'b0, 16'h0026);
    op(1'b0, 1'b1, 1'b0, 16'h000B);
    op(1'b1, 1'b1, 1'b0, 16'h0002);

    err_in = 4'b0010;
    op(1'b0, 1'b1, 1'b0, 16'h008B);
    @(negedge clk); chk("R3 masked", nmi_out, 1'b0);
    op(1'b0, 1'b1, 1'b0, 16'h000D);
    @(negedge clk); chk("R3 re-enabled", nmi_out, 1'b1);
    err_in = 4'b0000;

    op(1'b0, 1'b1, 1'b1, 16'h0685);
    op(1'b0, 1'b1, 1'b1, 16'h3090);
    rd_expect("R7 wide write to ram", 8'h30);
    op(1'b0, 1'b1, 1'b0, 16'h0010);

    for (int i = 0; i < 12; i++) begin
      op(1'b0, 1'b1, 1'b0, 16'(14 + i * 9));
      op(1'b1, 1'b1, 1'b0, 16'(8'h40 + i * 7));
    end
    for (int i = 0; i < 12; i++) begin
      op(1'b0, 1'b1, 1'b0, 16'(14 + i * 9));
      rd_expect("R4 sweep readback", 8'(8'h40 + i * 7));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule